// File: doc/BRIEF.md
# Reshapeable Dual-Port Synchronous RAM

This block is a synchronous on-chip RAM with two ports, A and B, sharing one fixed storage array. The array is `ROWS` rows of `ROW_W` bits. The defaults, 1024 rows of 18 bits, give 18 kbit: 16 data bits plus two parity-style bits per row. Each port has its own data width, which is a parameter. The port's depth follows from that width, so one array can be seen as 16K×1, 8K×2 or 4K×4 (with 16-bit rows), or as 2K×9 or 1K×18 (with 18-bit rows). The two ports may use different widths at the same time.

Both ports run on one shared clock. Each port has an enable, a write enable, an address, write data and registered read data. A read is only ever synchronous.

A mode parameter selects between two arrangements. In the simple arrangement, port A only writes and port B only reads. In the true arrangement, either port may read or write.

Each port has its own write-cycle output policy:
- keep-old: the output shows the contents before the write;
- show-new: the output shows the data being written;
- hold: the output keeps its previous value.

When both ports write overlapping bits on the same edge, port A's bits are stored and a collision flag is raised.

Top module: `dpram_cfg`

## Requirements
- R1: A port of width W has `ROWS*ROW_W/W` addresses, and the mapping is linear. Narrow address n holds storage bits n×W to n×W+W−1. A wide word at address k therefore covers narrow addresses k×ratio to k×ratio+ratio−1, with the lowest narrow address in its least significant bits.
- R2: An enabled cycle with write enable low loads the word at the address into the port's read data, visible after that clock edge. Locations never written read as zero.
- R3: While a port's enable is low, that port neither writes nor changes its read data, even if its write enable is high.
- R4: For a port set to keep-old (policy code 0), an enabled write stores the data, and the read data shows the contents from before the write.
- R5: For a port set to show-new (policy code 1), an enabled write stores the data, and the read data shows the written data.
- R6: For a port set to hold (policy code 2), an enabled write stores the data, and the read data keeps its previous value.
- R7: In simple mode (mode code 0), port A's read data stays zero and port B's write enable is ignored, so B always reads.
- R8: In true mode (mode code 1), when both ports write overlapping storage bits on one edge, the overlapping bits take port A's data. The `collide` output is then 1 for exactly the cycle after that edge; otherwise it is 0.
- R9: When one port reads storage bits that the other port writes on the same edge, the reading port returns the contents from before the write.
- R10: While `rst_n` is low, both read data outputs and `collide` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | A_AW | Port A address |
| a_wdata | input | A_W | Port A write data |
| a_rdata | output | A_W | Port A registered read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable (ignored in simple mode) |
| b_addr | input | B_AW | Port B address |
| b_wdata | input | B_W | Port B write data |
| b_rdata | output | B_W | Port B registered read data |
| collide | output | 1 | Same-edge overlapping write by both ports, registered |

## Verification
Every result is due one clock after the edge that samples its command:
- both read data outputs;
- the collision flag;
- the stored contents, which a later read exposes one edge after its own command.

The driver applies a command on a falling edge and pushes the matching expected outputs into a queue. The monitor pops one entry 1 ns after each following rising edge, so each comparison lands exactly one edge after its command, including back-to-back reads and writes to the same address. Three configurations cover every aspect-ratio class, each write policy, and both port arrangements.

// File: rtl/ramcfg_pkg.sv
package ramcfg_pkg;

  // Output behaviour of a port on its own write cycle.
  typedef enum logic [1:0] {
    WP_OLD  = 2'd0,
    WP_NEW  = 2'd1,
    WP_HOLD = 2'd2
  } wr_policy_e;

  // Port arrangement.
  typedef enum logic {
    PM_SIMPLE = 1'b0,
    PM_TRUE   = 1'b1
  } port_mode_e;

endpackage

// File: rtl/ramcfg_addr_split.sv
module ramcfg_addr_split #(
  parameter int ROWS  = 1024,
  parameter int ROW_W = 18,
  parameter int W     = 9,
  localparam int RATIO = ROW_W / W,
  localparam int LB    = $clog2(RATIO),
  localparam int RB    = $clog2(ROWS),
  localparam int AW    = RB + LB,
  localparam int OW    = (ROW_W > 1) ? $clog2(ROW_W) : 1
) (
  input  logic [AW-1:0] addr,
  output logic [RB-1:0] row,
  output logic [OW-1:0] off
);

  // Low address bits select a lane of the row; the lane's bit offset is lane*W.
  if (LB == 0) begin : g_whole
    assign row = addr;
    assign off = '0;
  end else begin : g_lane
    assign row = addr[AW-1:LB];
    assign off = OW'(addr[LB-1:0]) * OW'(W);
  end

endmodule

// File: rtl/ramcfg_rd_reg.sv
module ramcfg_rd_reg
  import ramcfg_pkg::*;
#(
  parameter int         W       = 9,
  parameter wr_policy_e POLICY  = WP_OLD,
  parameter bit         READ_ON = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         we,
  input  logic [W-1:0] old_word,
  input  logic [W-1:0] new_word,
  output logic [W-1:0] q
);

  logic         ld;
  logic [W-1:0] q_d;

  // Next-state selection and its clock enable.
  always_comb begin
    ld  = READ_ON && en && !(we && (POLICY == WP_HOLD));
    q_d = old_word;
    if (we && (POLICY == WP_NEW)) begin
      q_d = new_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (ld) begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/ramcfg_collide.sv
module ramcfg_collide #(
  parameter int RB = 10,
  parameter int OW = 5,
  parameter int WA = 9,
  parameter int WB = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr,
  input  logic          b_wr,
  input  logic [RB-1:0] a_row,
  input  logic [RB-1:0] b_row,
  input  logic [OW-1:0] a_off,
  input  logic [OW-1:0] b_off,
  output logic          flag
);

  logic hit;

  // Same row and intersecting bit ranges [off, off+W).
  always_comb begin
    hit = a_wr && b_wr && (a_row == b_row) &&
          (int'(a_off) < int'(b_off) + WB) &&
          (int'(b_off) < int'(a_off) + WA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else begin
      flag <= hit;
    end
  end

endmodule

// File: rtl/dpram_cfg.sv
module dpram_cfg
  import ramcfg_pkg::*;
#(
  parameter int         ROWS  = 1024,
  parameter int         ROW_W = 18,
  parameter int         A_W   = 9,
  parameter int         B_W   = 18,
  parameter port_mode_e MODE  = PM_TRUE,
  parameter wr_policy_e POL_A = WP_OLD,
  parameter wr_policy_e POL_B = WP_NEW,
  localparam int RB   = $clog2(ROWS),
  localparam int OW   = (ROW_W > 1) ? $clog2(ROW_W) : 1,
  localparam int A_AW = RB + $clog2(ROW_W / A_W),
  localparam int B_AW = RB + $clog2(ROW_W / B_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_en,
  input  logic            a_we,
  input  logic [A_AW-1:0] a_addr,
  input  logic [A_W-1:0]  a_wdata,
  output logic [A_W-1:0]  a_rdata,
  input  logic            b_en,
  input  logic            b_we,
  input  logic [B_AW-1:0] b_addr,
  input  logic [B_W-1:0]  b_wdata,
  output logic [B_W-1:0]  b_rdata,
  output logic            collide
);

  localparam bit TRUE_DP = (MODE == PM_TRUE);

  logic [ROW_W-1:0] mem [ROWS];

  logic [RB-1:0] a_row, b_row;
  logic [OW-1:0] a_off, b_off;
  logic          a_wr, b_wr, b_we_eff;
  logic [A_W-1:0] a_old;
  logic [B_W-1:0] b_old;

  ramcfg_addr_split #(.ROWS(ROWS), .ROW_W(ROW_W), .W(A_W)) u_split_a (
    .addr(a_addr), .row(a_row), .off(a_off)
  );

  ramcfg_addr_split #(.ROWS(ROWS), .ROW_W(ROW_W), .W(B_W)) u_split_b (
    .addr(b_addr), .row(b_row), .off(b_off)
  );

  // In simple mode B never writes; A always may.
  assign b_we_eff = TRUE_DP && b_we;
  assign a_wr     = a_en && a_we;
  assign b_wr     = b_en && b_we_eff;

  // Pre-edge contents of each port's lane (cross-port reads see old data).
  assign a_old = mem[a_row][a_off +: A_W];
  assign b_old = mem[b_row][b_off +: B_W];

  // Storage starts zero-filled; A's write is applied last so it wins overlaps.
  initial begin
    for (int i = 0; i < ROWS; i++) begin
      mem[i] = '0;
    end
  end

  always @(posedge clk) begin
    if (b_wr) begin
      mem[b_row][b_off +: B_W] <= b_wdata;
    end
    if (a_wr) begin
      mem[a_row][a_off +: A_W] <= a_wdata;
    end
  end

  ramcfg_rd_reg #(.W(A_W), .POLICY(POL_A), .READ_ON(TRUE_DP)) u_rd_a (
    .clk(clk), .rst_n(rst_n), .en(a_en), .we(a_we),
    .old_word(a_old), .new_word(a_wdata), .q(a_rdata)
  );

  ramcfg_rd_reg #(.W(B_W), .POLICY(POL_B), .READ_ON(1'b1)) u_rd_b (
    .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we_eff),
    .old_word(b_old), .new_word(b_wdata), .q(b_rdata)
  );

  ramcfg_collide #(.RB(RB), .OW(OW), .WA(A_W), .WB(B_W)) u_collide (
    .clk(clk), .rst_n(rst_n), .a_wr(a_wr), .b_wr(b_wr),
    .a_row(a_row), .b_row(b_row), .a_off(a_off), .b_off(b_off),
    .flag(collide)
  );

endmodule

// File: rtl/dpram_cfg_chk.sv
module dpram_cfg_chk
  import ramcfg_pkg::*;
#(
  parameter port_mode_e MODE  = PM_TRUE,
  parameter wr_policy_e POL_A = WP_OLD,
  parameter wr_policy_e POL_B = WP_NEW,
  parameter int A_W  = 9,
  parameter int B_W  = 18,
  parameter int A_AW = 11,
  parameter int B_AW = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            a_en,
  input logic            a_we,
  input logic [A_AW-1:0] a_addr,
  input logic [A_W-1:0]  a_wdata,
  input logic [A_W-1:0]  a_rdata,
  input logic            b_en,
  input logic            b_we,
  input logic [B_AW-1:0] b_addr,
  input logic [B_W-1:0]  b_wdata,
  input logic [B_W-1:0]  b_rdata,
  input logic            collide
);

  // R3: a disabled port keeps its read data
  p_a_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |=> $stable(a_rdata));
  p_b_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !b_en |=> $stable(b_rdata));

  // R8: the flag only follows a cycle in which both ports wrote
  p_collide_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> $past(a_en && a_we && b_en && b_we));

  if (MODE == PM_SIMPLE) begin : g_simple
    // R7: port A never shows read data; no collision without a B writer
    p_a_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      a_rdata == '0);
    p_no_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !collide);
  end else begin : g_true
    if (POL_A == WP_NEW) begin : g_a_new
      p_a_new_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        a_en && a_we |=> a_rdata == $past(a_wdata));
    end
    if (POL_A == WP_HOLD) begin : g_a_hold
      p_a_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        a_en && a_we |=> $stable(a_rdata));
    end
    if (POL_B == WP_NEW) begin : g_b_new
      p_b_new_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        b_en && b_we |=> b_rdata == $past(b_wdata));
    end
    if (POL_B == WP_HOLD) begin : g_b_hold
      p_b_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        b_en && b_we |=> $stable(b_rdata));
    end
  end

endmodule

bind dpram_cfg dpram_cfg_chk #(
  .MODE(MODE), .POL_A(POL_A), .POL_B(POL_B),
  .A_W(A_W), .B_W(B_W), .A_AW(A_AW), .B_AW(B_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
  .collide(collide)
);

// File: tb/dpram_cfg_hx.sv
module dpram_cfg_hx
  import ramcfg_pkg::*;
#(
  parameter int         ROWS  = 1024,
  parameter int         ROW_W = 18,
  parameter int         A_W   = 9,
  parameter int         B_W   = 18,
  parameter port_mode_e MODE  = PM_TRUE,
  parameter wr_policy_e POL_A = WP_OLD,
  parameter wr_policy_e POL_B = WP_NEW,
  parameter string      NAME  = "cfg"
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_cmp,
  output int   n_bad,
  output logic done
);

  localparam int RB   = $clog2(ROWS);
  localparam int AWA  = RB + $clog2(ROW_W / A_W);
  localparam int AWB  = RB + $clog2(ROW_W / B_W);
  localparam int TOT  = ROWS * ROW_W;
  localparam int AREA = 256;   // bit window for random traffic

  logic            a_en, a_we, b_en, b_we, col;
  logic [AWA-1:0]  a_addr;
  logic [AWB-1:0]  b_addr;
  logic [A_W-1:0]  a_wd, a_rd, ea;
  logic [B_W-1:0]  b_wd, b_rd, eb;
  logic [TOT-1:0]  shadow;

  typedef struct {
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
    logic           c;
    string          tag;
  } item_t;

  item_t sb[$];

  dpram_cfg #(
    .ROWS(ROWS), .ROW_W(ROW_W), .A_W(A_W), .B_W(B_W),
    .MODE(MODE), .POL_A(POL_A), .POL_B(POL_B)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wd), .a_rdata(a_rd),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wd), .b_rdata(b_rd),
    .collide(col)
  );

  task automatic judge(input item_t it);
    n_cmp++;
    if (a_rd !== it.a || b_rd !== it.b || col !== it.c) begin
      n_bad++;
      $display("FAIL %s %s: a_rdata=%h exp %h, b_rdata=%h exp %h, collide=%b exp %b",
               NAME, it.tag, a_rd, it.a, b_rd, it.b, col, it.c);
    end
  endtask

  // Driver: apply one command and queue the outputs due after the next edge.
  task automatic step(input logic ae, input logic aw, input int aa, input logic [A_W-1:0] ad,
                      input logic be, input logic bw, input int ba, input logic [B_W-1:0] bd,
                      input string tag);
    logic [A_W-1:0] oa;
    logic [B_W-1:0] ob;
    logic awr, bwr, c;
    @(negedge clk);
    a_en = ae; a_we = aw; a_addr = AWA'(aa); a_wd = ad;
    b_en = be; b_we = bw; b_addr = AWB'(ba); b_wd = bd;
    oa  = shadow[aa*A_W +: A_W];
    ob  = shadow[ba*B_W +: B_W];
    awr = ae && aw;
    bwr = be && bw && (MODE == PM_TRUE);
    if (MODE == PM_TRUE && ae) begin
      if (!aw || POL_A == WP_OLD) ea = oa;
      else if (POL_A == WP_NEW) ea = ad;
    end
    if (be) begin
      if (!bwr || POL_B == WP_OLD) eb = ob;
      else if (POL_B == WP_NEW) eb = bd;
    end
    c = awr && bwr && (aa*A_W < ba*B_W + B_W) && (ba*B_W < aa*A_W + A_W);
    if (bwr) shadow[ba*B_W +: B_W] = bd;
    if (awr) shadow[aa*A_W +: A_W] = ad;
    sb.push_back('{ea, eb, c, tag});
  endtask

  function automatic logic [31:0] rnd();
    return $urandom();
  endfunction

  // Monitor: one queued result per rising edge, sampled 1 ns later.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        judge(sb.pop_front());
      end
    end
  end

  initial begin
    logic [31:0] r1, r2;
    int lo, cnt, ca, cb;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    a_en = 0; a_we = 0; a_addr = '0; a_wd = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_wd = '0;
    shadow = '0; ea = '0; eb = '0;

    // R10: outputs cleared while reset is held
    @(negedge clk);
    judge('{'0, '0, 1'b0, "R10 reset state"});
    wait (rst_n === 1'b1);
    @(negedge clk);

    // R2: never-written locations read zero
    step(1, 0, 3, '0, 1, 0, 5, '0, "R2 unwritten reads zero");

    // R1: port A writes, port B reads the same bits through its own width
    for (int i = 0; i < 8; i++) begin
      r1 = rnd();
      step(1, 1, i, r1[A_W-1:0], 0, 0, 0, '0, "R1 A write");
    end
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0, 1, 0, i, '0, "R1 B linear read");

    // R1/R7: port B writes (ignored in simple mode), port A reads them back
    for (int i = 8; i < 12; i++) begin
      r1 = rnd();
      step(0, 0, 0, '0, 1, 1, i, r1[B_W-1:0], "R1/R7 B write");
    end
    lo  = 8 * B_W / A_W;
    cnt = (4 * B_W + A_W - 1) / A_W;
    if (cnt > 8) cnt = 8;
    for (int i = 0; i < cnt; i++) step(1, 0, lo + i, '0, 0, 0, 0, '0, "R1/R7 A read of B data");
    step(0, 0, 0, '0, 1, 0, 9, '0, "R7 B reads after B write");

    // R3: write enable with enable low changes nothing
    step(0, 1, 2, '1, 0, 1, 2, '1, "R3 disabled write");
    step(1, 0, 2, '0, 1, 0, 2, '0, "R3 nothing stored");

    // R4/R5/R6: back-to-back writes and a read on one address, per port
    r1 = rnd(); r2 = rnd();
    step(1, 1, 20, r1[A_W-1:0], 0, 0, 0, '0, "R4/R5/R6 A write 1");
    step(1, 1, 20, r2[A_W-1:0], 0, 0, 0, '0, "R4/R5/R6 A write 2");
    step(1, 0, 20, '0, 0, 0, 0, '0, "R2 A read after write");
    step(1, 1, 20, r1[A_W-1:0], 0, 0, 0, '0, "R4/R5/R6 A write 3");
    step(0, 0, 0, '0, 1, 1, 30, r1[B_W-1:0], "R4/R5/R6 B write 1");
    step(0, 0, 0, '0, 1, 1, 30, r2[B_W-1:0], "R4/R5/R6 B write 2");
    step(0, 0, 0, '0, 1, 0, 30, '0, "R2 B read after write");

    // R8: overlapping writes from both ports on one edge
    ca = 40 * B_W / A_W;
    r1 = rnd(); r2 = rnd();
    step(1, 1, ca, r1[A_W-1:0], 1, 1, 40, r2[B_W-1:0], "R8 overlapping writes");
    step(1, 0, ca, '0, 1, 0, 40, '0, "R8 A data wins");
    step(0, 0, 0, '0, 0, 0, 0, '0, "R8 flag drops");

    // R9: one port reads what the other writes on the same edge
    cb = 50; ca = 50 * B_W / A_W;
    r1 = rnd(); r2 = rnd();
    step(1, 1, ca, r1[A_W-1:0], 1, 0, cb, '0, "R9 B reads old under A write");
    step(1, 0, ca, '0, 1, 1, cb, r2[B_W-1:0], "R9 A reads old under B write");
    step(1, 0, ca, '0, 1, 0, cb, '0, "R9 settled contents");

    // Mixed traffic in a small bit window to force hits and overlaps
    for (int i = 0; i < 400; i++) begin
      r1 = rnd(); r2 = rnd();
      step(r1[0], r1[1], $urandom_range(0, AREA / A_W - 1), r1[31:32-A_W],
           r2[0], r2[1], $urandom_range(0, AREA / B_W - 1), r2[31:32-B_W],
           "R2/R3/R4/R5/R6/R8/R9 mixed");
    end
    step(0, 0, 0, '0, 0, 0, 0, '0, "R3 idle drain");

    wait (sb.size() == 0);
    @(negedge clk);
    done = 1'b1;
  end

endmodule

// File: tb/dpram_cfg_tb.sv
module dpram_cfg_tb;
  import ramcfg_pkg::*;

  logic clk;
  logic rst_n;
  int   c0, b0, c1, b1, c2, b2;
  logic d0, d1, d2;
  int   cycles;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  initial begin
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
  end

  // 2K x 9 against 1K x 18, keep-old on A, show-new on B
  dpram_cfg_hx #(.ROWS(1024), .ROW_W(18), .A_W(9), .B_W(18), .MODE(PM_TRUE),
                 .POL_A(WP_OLD), .POL_B(WP_NEW), .NAME("x9_x18")) u_h0 (
    .clk(clk), .rst_n(rst_n), .n_cmp(c0), .n_bad(b0), .done(d0));

  // 16K x 1 against 4K x 4, hold on A, keep-old on B
  dpram_cfg_hx #(.ROWS(1024), .ROW_W(16), .A_W(1), .B_W(4), .MODE(PM_TRUE),
                 .POL_A(WP_HOLD), .POL_B(WP_OLD), .NAME("x1_x4")) u_h1 (
    .clk(clk), .rst_n(rst_n), .n_cmp(c1), .n_bad(b1), .done(d1));

  // Simple mode: 1K x 16 writer, 8K x 2 reader
  dpram_cfg_hx #(.ROWS(1024), .ROW_W(16), .A_W(16), .B_W(2), .MODE(PM_SIMPLE),
                 .POL_A(WP_NEW), .POL_B(WP_HOLD), .NAME("sdp_x16_x2")) u_h2 (
    .clk(clk), .rst_n(rst_n), .n_cmp(c2), .n_bad(b2), .done(d2));

  initial begin
    int wd;
    wd = 0;
    cycles = 0;
    while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (cycles >= 20000) begin
      wd = 1;
      $display("FAIL watchdog: done flags=%b%b%b exp 111", d0, d1, d2);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             c0 + c1 + c2 + wd, b0 + b1 + b2 + wd);
    $finish;
  end

endmodule